// File: doc/BRIEF.md
# Serial Status Word Readout Slave

This block is the serial-bus slave front end of a radio receiver's control port. The select, clock and data inputs from an external host are resynchronised into the system clock domain. The block then decodes the opening command bit. A leading 0 means a status read. The block answers at once on the serial output with a 16-position status word, and after the word it continues with bytes pulled from a receive FIFO for as long as the host keeps clocking. A leading 1 means a control command. The block shifts in the complete 16-bit word and presents it on a parallel port with a one-cycle strobe.

Three event flags are sticky: FIFO overflow, wake-up timer expiry and supply-low. An event sets its flag, and the flag is cleared by a read that reaches at least the fourth status position. The other twelve status inputs are live and are sampled at the moment their position is shifted out. An active-low interrupt output is asserted while the FIFO fill flag or any sticky flag is set.

Top module: `stat_spi_rdout`

## Requirements
- R1: While select is low and no clock edge has yet occurred, `sdo_o` follows the live `fifo_it_i` input.
- R2: With a first command bit of 0, the host samples at its clock rising edges, in this order: position 0 `fifo_it_i`, position 1 overflow flag, position 2 wake-up flag, position 3 supply-low flag, and positions 4 to 15 `live_i[0]` to `live_i[11]`. Each position is driven after the preceding falling edge of the clock.
- R3: A one-cycle pulse on `evt_ovf_i`, `evt_wake_i` or `evt_lowbat_i` sets its flag, and the flag stays set until it is cleared by R4.
- R4: When select rises after a read in which at least 4 rising clock edges were seen, all three flags are cleared. A read that ends after 3 or fewer edges leaves them unchanged.
- R5: An event pulse that arrives after the read decision of a transaction is reported as set in the following read.
- R6: After position 15, `sdo_o` carries `fifo_byte_i`, most significant bit first. `fifo_pop_o` pulses once after every 8th data bit has been sampled, and the next byte follows it.
- R7: With a first bit of 1, the 16 bits are shifted in first bit to most significant bit. On the rise of select the word appears on `cmd_word_o` with `cmd_valid_o` high for exactly one cycle. `sdo_o` stays low for the whole command. Back-to-back commands are each delivered.
- R8: A control command that ends with a bit count other than 16 produces no strobe and leaves `cmd_word_o` unchanged.
- R9: `irq_n_o` is low one cycle after `fifo_it_i` or any sticky flag is high, and high otherwise.
- R10: After reset, `sdo_o`=0, `irq_n_o`=1, `cmd_valid_o`=0 and `cmd_word_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| irq_n_o | output | 1 | Interrupt, active low |
| fifo_it_i | input | 1 | FIFO fill level reached (live) |
| evt_ovf_i | input | 1 | FIFO overflow event pulse |
| evt_wake_i | input | 1 | Wake-up timer expiry event pulse |
| evt_lowbat_i | input | 1 | Supply-low event pulse |
| live_i | input | 12 | Live status bits, bit j sent at position j+4 |
| fifo_byte_i | input | BYTE_W | Byte at the head of the receive FIFO |
| fifo_pop_o | output | 1 | One-cycle pulse: head byte consumed |
| cmd_word_o | output | CMD_W | Last complete control command |
| cmd_valid_o | output | 1 | One-cycle strobe for a new command |

## Verification
The assertions assume that the host holds every serial clock level for several system clocks. This keeps each edge visible once after the two-stage synchroniser. They also assume that select changes only while the serial clock is low, and that event inputs are single-cycle pulses. The bench meets these assumptions by holding each clock phase for eight system cycles. It changes select and data only in the low phase, and it pulses events for one cycle on the falling system edge.

// File: rtl/stat_spi_pkg.sv
package stat_spi_pkg;
  localparam int NUM_STICKY = 3;
  localparam int LIVE_W     = 12;
  localparam int STAT_W     = 1 + NUM_STICKY + LIVE_W;
  localparam int CLR_MIN    = NUM_STICKY + 1;

  typedef enum logic [1:0] {M_IDLE, M_FIRST, M_READ, M_CTRL} mode_e;

  // Status word: position 0 fill flag, 1..3 sticky flags, then live bits.
  function automatic logic [STAT_W-1:0] pack_status(
      input logic fill, input logic [NUM_STICKY-1:0] sticky,
      input logic [LIVE_W-1:0] live);
    return {live, sticky, fill};
  endfunction
endpackage

// File: rtl/stat_spi_sync.sv
module stat_spi_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg[s-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= RST_VAL;
    else        prev <= stg[STAGES-1];

  assign q    = stg[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/stat_spi_evlatch.sv
module stat_spi_evlatch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         rd_active,
  input  logic         clr,
  output logic [N-1:0] latched
);
  logic [N-1:0] pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      latched <= '0;
      pend    <= '0;
    end else begin
      latched <= clr ? (pend | evt) : (latched | evt);
      pend    <= (clr || !rd_active) ? '0 : (pend | evt);
    end
endmodule

// File: rtl/stat_spi_shift.sv
module stat_spi_shift
  import stat_spi_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CMD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              cs_end,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi,
  input  logic [STAT_W-1:0] word,
  input  logic [BYTE_W-1:0] fifo_byte,
  output mode_e             mode,
  output logic              sdo_q,
  output logic              fifo_pop,
  output logic [CMD_W-1:0]  cmd_word,
  output logic              cmd_valid,
  output logic              clr_latched
);
  localparam int MAXC   = (CMD_W > STAT_W) ? CMD_W : STAT_W;
  localparam int POS_W  = $clog2(MAXC + 2);
  localparam int SIDX_W = $clog2(STAT_W);
  localparam int IDX_W  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [POS_W-1:0] POS_STAT = POS_W'(STAT_W);
  localparam logic [POS_W-1:0] POS_CMD  = POS_W'(CMD_W);
  localparam logic [IDX_W-1:0] FB_LAST  = IDX_W'(BYTE_W - 1);

  logic [POS_W-1:0] pos;
  logic [IDX_W-1:0] fb;
  logic [CMD_W-1:0] shreg;

  function automatic logic byte_bit(input logic [BYTE_W-1:0] b,
                                    input logic [IDX_W-1:0] idx);
    return b[FB_LAST - idx];
  endfunction

  assign clr_latched = cs_end && (mode == M_READ) && (pos >= POS_W'(CLR_MIN));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= M_IDLE; pos <= '0; fb <= '0; shreg <= '0; sdo_q <= 1'b0;
      fifo_pop <= 1'b0; cmd_word <= '0; cmd_valid <= 1'b0;
    end else begin
      fifo_pop  <= 1'b0;
      cmd_valid <= 1'b0;
      if (cs_end || !sel) begin
        if (cs_end && mode == M_CTRL && pos == POS_CMD) begin
          cmd_word  <= shreg;
          cmd_valid <= 1'b1;
        end
        mode <= M_IDLE; pos <= '0; fb <= '0; sdo_q <= 1'b0;
      end else begin
        unique case (mode)
          M_IDLE: mode <= M_FIRST;
          M_FIRST: if (sck_rise) begin
            pos <= POS_W'(1);
            if (!sdi) begin
              mode  <= M_READ;
              sdo_q <= word[0];
            end else begin
              mode  <= M_CTRL;
              shreg <= CMD_W'(1);
            end
          end
          M_READ: begin
            if (sck_rise) begin
              if (pos < POS_STAT) pos <= pos + 1'b1;
              else if (fb == FB_LAST) begin
                fb       <= '0;
                fifo_pop <= 1'b1;
              end else fb <= fb + 1'b1;
            end
            if (sck_fall)
              sdo_q <= (pos < POS_STAT) ? word[pos[SIDX_W-1:0]]
                                        : byte_bit(fifo_byte, fb);
          end
          M_CTRL: if (sck_rise) begin
            shreg <= {shreg[CMD_W-2:0], sdi};
            if (pos <= POS_CMD) pos <= pos + 1'b1;
          end
          default: mode <= M_IDLE;
        endcase
      end
    end
endmodule

// File: rtl/stat_spi_rdout.sv
module stat_spi_rdout
  import stat_spi_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CMD_W  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n_i,
  input  logic                sck_i,
  input  logic                sdi_i,
  output logic                sdo_o,
  output logic                irq_n_o,
  input  logic                fifo_it_i,
  input  logic                evt_ovf_i,
  input  logic                evt_wake_i,
  input  logic                evt_lowbat_i,
  input  logic [LIVE_W-1:0]   live_i,
  input  logic [BYTE_W-1:0]   fifo_byte_i,
  output logic                fifo_pop_o,
  output logic [CMD_W-1:0]    cmd_word_o,
  output logic                cmd_valid_o
);
  logic [2:0] s_q, s_rise, s_fall;
  logic       cs_end, sck_rise, sck_fall, sel;
  logic [NUM_STICKY-1:0] evt_vec, latched;
  logic [STAT_W-1:0] stat_word;
  logic       sdo_q, clr_latched, irq_n_q;
  mode_e      mode;

  stat_spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({sdi_i, sck_i, sel_n_i}),
    .q(s_q), .rise(s_rise), .fall(s_fall));

  assign sel      = ~s_q[0];
  assign cs_end   = s_rise[0];
  assign sck_rise = s_rise[1];
  assign sck_fall = s_fall[1];
  assign evt_vec  = {evt_lowbat_i, evt_wake_i, evt_ovf_i};

  stat_spi_evlatch #(.N(NUM_STICKY)) evl_i (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .rd_active(mode == M_READ),
    .clr(clr_latched), .latched(latched));

  assign stat_word = pack_status(fifo_it_i, latched, live_i);

  stat_spi_shift #(.BYTE_W(BYTE_W), .CMD_W(CMD_W)) shf_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .cs_end(cs_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi(s_q[2]),
    .word(stat_word), .fifo_byte(fifo_byte_i), .mode(mode), .sdo_q(sdo_q),
    .fifo_pop(fifo_pop_o), .cmd_word(cmd_word_o), .cmd_valid(cmd_valid_o),
    .clr_latched(clr_latched));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_n_q <= 1'b1;
    else        irq_n_q <= ~(fifo_it_i | (|latched));

  assign irq_n_o = irq_n_q;
  assign sdo_o   = (mode == M_FIRST) ? stat_word[0]
                 : (mode == M_READ)  ? sdo_q : 1'b0;
endmodule

// File: rtl/stat_spi_chk.sv
module stat_spi_chk
  import stat_spi_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input mode_e mode,
  input logic sdo_o,
  input logic cmd_valid_o,
  input logic cs_end,
  input logic [NUM_STICKY-1:0] evt_vec,
  input logic [NUM_STICKY-1:0] latched,
  input logic fifo_it_i,
  input logic irq_n_o,
  input logic fifo_pop_o
);
  // R7: control command keeps the output low
  a_r7_ctrl_sdo_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CTRL) |-> !sdo_o);
  // R7: strobe lasts one cycle
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  // R8: strobe only follows the end of a transaction
  a_r8_valid_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(cs_end));
  // R3: an event is captured in its flag on the next cycle
  a_r3_event_held: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_vec) |=> ((latched & $past(evt_vec)) == $past(evt_vec)));
  // R9: fill flag drives the interrupt low
  a_r9_irq_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_it_i |=> !irq_n_o);
  // R6: FIFO bytes are consumed only during a read
  a_r6_pop_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> ($past(mode) == M_READ));
endmodule

bind stat_spi_rdout stat_spi_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sdo_o(sdo_o),
  .cmd_valid_o(cmd_valid_o), .cs_end(cs_end), .evt_vec(evt_vec),
  .latched(latched), .fifo_it_i(fifo_it_i), .irq_n_o(irq_n_o),
  .fifo_pop_o(fifo_pop_o));

// File: tb/stat_spi_rdout_tb.sv
module stat_spi_rdout_tb_top;
  localparam int HALF = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic fifo_it = 1'b0, e_ovf = 1'b0, e_wake = 1'b0, e_low = 1'b0;
  logic [11:0] live = '0;
  logic [7:0] fbyte;
  logic sdo, irq_n, pop, cvalid;
  logic [15:0] cword;
  int checks = 0, fails = 0, pops = 0, nvalid = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stat_spi_rdout dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .irq_n_o(irq_n), .fifo_it_i(fifo_it), .evt_ovf_i(e_ovf),
    .evt_wake_i(e_wake), .evt_lowbat_i(e_low), .live_i(live),
    .fifo_byte_i(fbyte), .fifo_pop_o(pop), .cmd_word_o(cword),
    .cmd_valid_o(cvalid));

  function automatic logic [7:0] byte_of(input int k);
    return 8'h3C + 8'(k) * 8'h47;
  endfunction

  initial fbyte = byte_of(0);
  initial forever begin
    @(negedge clk);
    if (pop) begin pops++; fbyte = byte_of(pops); end
    if (cvalid) nvalid++;
  end

  task automatic chk(input bit ok, input string req, input logic [47:0] act,
                     input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [2:0] m);
    {e_low, e_wake, e_ovf} = m;
    @(negedge clk);
    {e_low, e_wake, e_ovf} = 3'b000;
  endtask

  // read of nb bits; event pulse m injected after falling edge number at
  task automatic do_read(input int nb, input int at, input logic [2:0] m,
                         output logic [47:0] got);
    got = '0;
    sel_n = 1'b0; sdi = 1'b0;
    wait_n(HALF);
    for (int i = 0; i < nb; i++) begin
      got[i] = sdo;
      sck = 1'b1; wait_n(HALF);
      sck = 1'b0;
      if (i == at) begin pulse(m); wait_n(HALF - 1); end
      else wait_n(HALF);
    end
    sel_n = 1'b1; wait_n(HALF);
  endtask

  task automatic do_cmd(input int nb, input logic [15:0] w, output bit sdo_hi);
    sdo_hi = 0;
    sel_n = 1'b0;
    for (int i = 0; i < nb; i++) begin
      sdi = w[15 - (i % 16)];
      wait_n(HALF);
      if (sdo) sdo_hi = 1;
      sck = 1'b1; wait_n(HALF);
      if (sdo) sdo_hi = 1;
      sck = 1'b0;
    end
    wait_n(HALF);
    sel_n = 1'b1; sdi = 1'b0; wait_n(HALF);
  endtask

  function automatic logic [15:0] exp_stat(input logic f, input logic [2:0] s,
                                           input logic [11:0] l);
    return {l, s, f};
  endfunction

  task automatic t_reset;
    chk(sdo == 0, "R10 sdo", 48'(sdo), 0);
    chk(irq_n == 1, "R10 irq_n", 48'(irq_n), 1);
    chk(cvalid == 0 && cword == 0, "R10 cmd", 48'({cvalid, cword}), 0);
  endtask

  task automatic t_idle_poll;
    sel_n = 1'b0; fifo_it = 1'b1; wait_n(HALF);
    chk(sdo == 1, "R1 poll high", 48'(sdo), 1);
    chk(irq_n == 0, "R9 fill irq", 48'(irq_n), 0);
    fifo_it = 1'b0; wait_n(4);
    chk(sdo == 0, "R1 poll low", 48'(sdo), 0);
    sel_n = 1'b1; wait_n(HALF);
    chk(irq_n == 1, "R9 irq release", 48'(irq_n), 1);
  endtask

  task automatic t_full_read;
    logic [47:0] got, exp;
    int p0;
    pulse(3'b101); wait_n(2);
    chk(irq_n == 0, "R9 sticky irq", 48'(irq_n), 0);
    live = 12'hA5C; p0 = pops;
    do_read(32, -1, 3'b000, got);
    exp = {16'h0, byte_of(1), byte_of(0), exp_stat(1'b0, 3'b101, live)};
    for (int b = 0; b < 8; b++) begin
      exp[16+b] = byte_of(0)[7-b];
      exp[24+b] = byte_of(1)[7-b];
    end
    chk(got[15:0] == exp[15:0], "R2 status order", 48'(got[15:0]), 48'(exp[15:0]));
    chk(got[31:16] == exp[31:16], "R6 fifo data", 48'(got[31:16]), 48'(exp[31:16]));
    chk(pops - p0 == 2, "R6 pop count", 48'(pops - p0), 2);
    chk(irq_n == 1, "R4 irq after clear", 48'(irq_n), 1);
    do_read(4, -1, 3'b000, got);
    chk(got[3:1] == 0, "R4 cleared", 48'(got[3:1]), 0);
  endtask

  task automatic t_short_read;
    logic [47:0] got;
    pulse(3'b010); wait_n(2);
    do_read(3, -1, 3'b000, got);
    chk(got[2] == 1, "R3 wake held", 48'(got[2]), 1);
    do_read(4, -1, 3'b000, got);
    chk(got[3:1] == 3'b010, "R4 short read keeps", 48'(got[3:1]), 48'(3'b010));
    do_read(4, -1, 3'b000, got);
    chk(got[3:1] == 0, "R4 four-bit clear", 48'(got[3:1]), 0);
  endtask

  task automatic t_mid_event;
    logic [47:0] got;
    pulse(3'b001); wait_n(2);
    do_read(8, 5, 3'b010, got);
    chk(got[3:1] == 3'b001, "R5 current read", 48'(got[3:1]), 48'(3'b001));
    do_read(4, -1, 3'b000, got);
    chk(got[3:1] == 3'b010, "R5 next read", 48'(got[3:1]), 48'(3'b010));
  endtask

  task automatic t_ctrl;
    bit hi;
    int v0 = nvalid;
    do_cmd(16, 16'hB2E7, hi);
    chk(!hi, "R7 sdo low", 48'(hi), 0);
    chk(nvalid - v0 == 1 && cword == 16'hB2E7, "R7 first cmd",
        48'({nvalid - v0, cword}), 48'({32'd1, 16'hB2E7}));
    do_cmd(16, 16'h8001, hi);
    chk(nvalid - v0 == 2 && cword == 16'h8001, "R7 back-to-back",
        48'({nvalid - v0, cword}), 48'({32'd2, 16'h8001}));
    do_cmd(10, 16'hFFC0, hi);
    chk(nvalid - v0 == 2 && cword == 16'h8001, "R8 short cmd",
        48'({nvalid - v0, cword}), 48'({32'd2, 16'h8001}));
    do_cmd(17, 16'hC000, hi);
    chk(nvalid - v0 == 2 && cword == 16'h8001, "R8 long cmd",
        48'({nvalid - v0, cword}), 48'({32'd2, 16'h8001}));
  endtask

  initial begin
    wait_n(3);
    t_reset;
    rst_n = 1'b1; wait_n(4);
    t_idle_poll;
    t_full_read;
    t_short_read;
    t_mid_event;
    t_ctrl;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule